// File: doc/BRIEF.md
# Video DMA Source Sequencer

This block drives the source side of a video processor's DMA engine. Each time an access slot arrives, it may produce one entry for the timed write FIFO. An entry carries a destination address, a value, the command code, a partial-write marker and a ready time. Three source modes are supported:

- **External transfer** reads words from the external CPU bus.
- **Fill** repeats the value most recently written to the data port.
- **Copy** reads back from the internal memory that matches the destination: pattern RAM, colour RAM or scroll RAM.

Software-side registers are loaded through a small register write port and a command write that sets the command code and the destination address. Data-port writes also pass through the block. They are enqueued as ordinary entries, and in fill mode they start the fill. The slot counter, the width mode, the current time and the FIFO status come in from outside. The memories answer combinationally on their read ports.

Top module: `dma_src_seq`

## Requirements
- R1: The source mode is taken from bits 7:6 of the source-high register (register select 2). 00 and 01 select external transfer, 10 selects fill, and 11 selects copy. The other register selects are 0 source low, 1 source mid, 3 length low, 4 length high and 5 auto-increment.
- R2: In refresh slots no entry is produced and no source read is issued. With `wide_mode`=1 the refresh slots are 37, 69, 102, 133, 165, 197 and every slot of 210 or above. With `wide_mode`=0 they are 24, 56, 88, 120 and 152.
- R3: In external mode, `ext_rd` pulses and an entry is produced only when the slot is not a refresh slot and either the slot is 0 or the preceding slot number is not a refresh slot. `ext_addr` is {source high, source mid, source low}, and the entry value is `ext_data`.
- R4: In copy mode, an entry is produced only in a slot where `unused_slot` is high, and `unused_clr` pulses in that same cycle. The value depends on the destination, given by command code bits 3:0:
  - Code 1 (pattern RAM) gives {8'h00, `vram_rdata`} read at {mid, low}.
  - Code 3 (colour RAM) gives `cram_rdata` read at the low byte masked to the colour RAM size.
  - Code 5 (scroll RAM) gives `vsram_rdata` read at low mod 64, or 0 when that index is not below the scroll RAM depth.
  - Copy entries have `fe_partial`=0.
- R5: In fill mode each entry has `fe_partial`=1. Its value is the last data-port value, shifted down to its high byte when the destination code is 1.
- R6: While `fifo_full` is high, no entry is produced, no source read is issued and data-port writes are not accepted.
- R7: After each DMA entry, {source mid, source low} increments by one (the source high register is unchanged), the destination address adds the auto-increment value, and the length decrements.
- R8: When the length reaches zero, `dma_running` clears and the command code keeps only bits 3:0. A length of 0 at start yields 65536 entries.
- R9: In fill mode a command write does not start the DMA. An accepted data-port write with command bit 5 set is enqueued, and `dma_running` is then high from the next cycle on.
- R10: While a non-fill DMA runs, data-port writes are rejected (`data_accept`=0). An accepted data-port write produces an entry with the current destination address, the written value, `fe_partial`=0 and the current command code, and then advances the destination by the auto-increment.
- R11: Every entry's `fe_ready` equals `now` in the producing cycle plus 48 when `wide_mode`=1, or plus 60 when `wide_mode`=0.
- R12: After reset nothing runs and no entry is output. A command write loads the command code and the destination address, and when code bit 5 is set outside fill mode it starts the DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 6 | Command code |
| cmd_addr | input | 16 | Destination address |
| data_we | input | 1 | Data-port write strobe |
| data_wval | input | 16 | Data-port value |
| data_accept | output | 1 | Data-port write taken this cycle |
| slot_tick | input | 1 | Access slot strobe |
| slot_num | input | 8 | Current slot number |
| wide_mode | input | 1 | 1 = wide display mode |
| now | input | 32 | Current time in master clocks |
| fifo_full | input | 1 | Write FIFO is full |
| unused_slot | input | 1 | FIFO left this slot idle |
| unused_clr | output | 1 | Copy consumed the idle slot |
| ext_rd | output | 1 | External bus read strobe |
| ext_addr | output | 24 | External bus read address |
| ext_data | input | 16 | External bus read data |
| vram_raddr | output | 16 | Pattern RAM read address |
| vram_rdata | input | 8 | Pattern RAM read data |
| cram_raddr | output | 6 | Colour RAM read address |
| cram_rdata | input | 16 | Colour RAM read data |
| vsram_raddr | output | 6 | Scroll RAM read address |
| vsram_rdata | input | 16 | Scroll RAM read data |
| dma_running | output | 1 | DMA in progress |
| fe_valid | output | 1 | FIFO entry valid |
| fe_addr | output | 16 | Entry destination address |
| fe_value | output | 16 | Entry value |
| fe_code | output | 6 | Entry command code |
| fe_partial | output | 1 | Entry partial marker |
| fe_ready | output | 32 | Entry ready time |

## Verification
The hardest case to reach is the interaction between refresh slots and the slot that follows them in external mode. Reaching it needs an endless run and every slot number in both width modes. The bench therefore starts a zero-length (65536-word) external transfer and sweeps slots 0 to 255 in each width. It predicts each read from the refresh list and tracks the source address across a carry from low into mid. The other cases bench-checked are the 65536-entry end of a zero-length fill, and scroll-RAM copies that step past the end of the scroll RAM.

// File: rtl/dma_src_seq.sv
module dma_src_seq #(
  parameter int CRAM_DEPTH  = 64,
  parameter int VSRAM_DEPTH = 40,
  parameter int WIDE_SLOT   = 16,
  parameter int NARROW_SLOT = 20,
  parameter int LATENCY     = 3,
  localparam int CA_W = $clog2(CRAM_DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        cmd_we,
  input  logic [5:0]  cmd_code,
  input  logic [15:0] cmd_addr,
  input  logic        data_we,
  input  logic [15:0] data_wval,
  output logic        data_accept,
  input  logic        slot_tick,
  input  logic [7:0]  slot_num,
  input  logic        wide_mode,
  input  logic [31:0] now,
  input  logic        fifo_full,
  input  logic        unused_slot,
  output logic        unused_clr,
  output logic        ext_rd,
  output logic [23:0] ext_addr,
  input  logic [15:0] ext_data,
  output logic [15:0] vram_raddr,
  input  logic [7:0]  vram_rdata,
  output logic [CA_W-1:0] cram_raddr,
  input  logic [15:0] cram_rdata,
  output logic [5:0]  vsram_raddr,
  input  logic [15:0] vsram_rdata,
  output logic        dma_running,
  output logic        fe_valid,
  output logic [15:0] fe_addr,
  output logic [15:0] fe_value,
  output logic [5:0]  fe_code,
  output logic        fe_partial,
  output logic [31:0] fe_ready
);
  localparam logic [31:0] WIDE_LAT   = 32'(WIDE_SLOT * LATENCY);
  localparam logic [31:0] NARROW_LAT = 32'(NARROW_SLOT * LATENCY);

  logic [7:0]  src_hi, src_mid, src_lo, autoinc;
  logic [15:0] len, dest, last_val;
  logic [5:0]  cd;
  logic        run;

  function automatic logic is_ref(input logic [7:0] s, input logic w);
    if (w) return s == 8'd37 || s == 8'd69 || s == 8'd102 || s == 8'd133 ||
                  s == 8'd165 || s == 8'd197 || s >= 8'd210;
    return s == 8'd24 || s == 8'd56 || s == 8'd88 || s == 8'd120 || s == 8'd152;
  endfunction

  wire [1:0]  mode     = src_hi[7:6];
  wire        is_ext   = !mode[1];
  wire        is_fill  = mode == 2'b10;
  wire        is_copy  = mode == 2'b11;
  wire [3:0]  dst      = cd[3:0];
  wire [15:0] len_next = len - 16'd1;

  assign data_accept = data_we && !fifo_full && !(run && !is_fill);
  wire src_go = run && slot_tick && !data_accept && !fifo_full && !is_ref(slot_num, wide_mode);
  assign ext_rd     = src_go && is_ext && (slot_num == 8'd0 || !is_ref(slot_num - 8'd1, wide_mode));
  assign unused_clr = src_go && is_copy && unused_slot;
  wire produce = ext_rd || unused_clr || (src_go && is_fill);

  assign ext_addr    = {src_hi, src_mid, src_lo};
  assign vram_raddr  = {src_mid, src_lo};
  assign cram_raddr  = src_lo[CA_W-1:0];
  assign vsram_raddr = src_lo[5:0];
  assign dma_running = run;

  wire vsram_ok = 32'(src_lo[5:0]) < VSRAM_DEPTH;
  logic [15:0] copy_val;
  always_comb
    case (dst)
      4'h1:    copy_val = {8'h00, vram_rdata};
      4'h3:    copy_val = cram_rdata;
      4'h5:    copy_val = vsram_ok ? vsram_rdata : 16'h0000;
      default: copy_val = 16'h0000;
    endcase
  wire [15:0] fill_val = (dst == 4'h1) ? {8'h00, last_val[15:8]} : last_val;
  wire [15:0] src_val  = is_ext ? ext_data : (is_copy ? copy_val : fill_val);
  wire [31:0] ready_at = now + (wide_mode ? WIDE_LAT : NARROW_LAT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {src_hi, src_mid, src_lo, autoinc} <= '0;
      {len, dest, last_val, cd, run}     <= '0;
      {fe_valid, fe_addr, fe_value, fe_code, fe_partial, fe_ready} <= '0;
    end else begin
      fe_valid <= 1'b0;
      if (reg_we)
        case (reg_sel)
          3'd0: src_lo    <= reg_wdata;
          3'd1: src_mid   <= reg_wdata;
          3'd2: src_hi    <= reg_wdata;
          3'd3: len[7:0]  <= reg_wdata;
          3'd4: len[15:8] <= reg_wdata;
          3'd5: autoinc   <= reg_wdata;
          default: ;
        endcase
      if (cmd_we) begin
        cd   <= cmd_code;
        dest <= cmd_addr;
        if (cmd_code[5] && !is_fill) run <= 1'b1;
      end
      if (data_accept) begin
        fe_valid   <= 1'b1;
        fe_addr    <= dest;
        fe_value   <= data_wval;
        fe_code    <= cd;
        fe_partial <= 1'b0;
        fe_ready   <= ready_at;
        last_val   <= data_wval;
        dest       <= dest + {8'h00, autoinc};
        if (is_fill && cd[5]) run <= 1'b1;
      end else if (produce) begin
        fe_valid   <= 1'b1;
        fe_addr    <= dest;
        fe_value   <= src_val;
        fe_code    <= cd;
        fe_partial <= is_fill;
        fe_ready   <= ready_at;
        {src_mid, src_lo} <= {src_mid, src_lo} + 16'd1;
        dest <= dest + {8'h00, autoinc};
        len  <= len_next;
        if (len_next == 16'd0) begin
          run <= 1'b0;
          cd  <= {2'b00, cd[3:0]};
        end
      end
    end

  assert_refresh_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && is_ref(slot_num, wide_mode) && !data_we) |=> !fe_valid);
  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> !fe_valid);
  assert_copy_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && is_copy && !unused_slot && !data_we) |=> !fe_valid);
  assert_end_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> cd[5:4] == 2'b00);
  assert_ready_time_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fe_valid |-> fe_ready == $past(now) + ($past(wide_mode) ? WIDE_LAT : NARROW_LAT));
endmodule

// File: tb/dma_src_seq_test.sv
module dma_src_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic reg_we = 0, cmd_we = 0, data_we = 0, slot_tick = 0, wide_mode = 0;
  logic fifo_full = 0, unused_slot = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, slot_num = 0;
  logic [5:0] cmd_code = 0;
  logic [15:0] cmd_addr = 0, data_wval = 0;
  logic [31:0] tnow = 0;
  logic data_accept, unused_clr, ext_rd, dma_running, fe_valid, fe_partial;
  logic [23:0] ext_addr;
  logic [15:0] ext_data, vram_raddr, cram_rdata, vsram_rdata, fe_addr, fe_value;
  logic [7:0] vram_rdata;
  logic [5:0] cram_raddr, vsram_raddr, fe_code;
  logic [31:0] fe_ready;

  always @(posedge clk) tnow <= tnow + 1;
  assign ext_data    = ext_addr[15:0] ^ 16'h5A3C;
  assign vram_rdata  = vram_raddr[7:0] ^ vram_raddr[15:8] ^ 8'h11;
  assign cram_rdata  = {4'hC, cram_raddr, cram_raddr};
  assign vsram_rdata = 16'hE000 | {10'h0, vsram_raddr};

  dma_src_seq uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_we(cmd_we), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .data_we(data_we), .data_wval(data_wval), .data_accept(data_accept),
    .slot_tick(slot_tick), .slot_num(slot_num), .wide_mode(wide_mode), .now(tnow),
    .fifo_full(fifo_full), .unused_slot(unused_slot), .unused_clr(unused_clr),
    .ext_rd(ext_rd), .ext_addr(ext_addr), .ext_data(ext_data),
    .vram_raddr(vram_raddr), .vram_rdata(vram_rdata), .cram_raddr(cram_raddr),
    .cram_rdata(cram_rdata), .vsram_raddr(vsram_raddr), .vsram_rdata(vsram_rdata),
    .dma_running(dma_running), .fe_valid(fe_valid), .fe_addr(fe_addr),
    .fe_value(fe_value), .fe_code(fe_code), .fe_partial(fe_partial), .fe_ready(fe_ready));

  int total = 0, bad = 0;
  logic c_ext, c_clr, c_acc;
  logic [23:0] c_eaddr;
  logic [31:0] c_now;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit bref(int s, bit w);
    if (w) return s == 37 || s == 69 || s == 102 || s == 133 || s == 165 || s == 197 || s >= 210;
    return s == 24 || s == 56 || s == 88 || s == 120 || s == 152;
  endfunction

  function automatic logic [31:0] lat(bit w);
    return w ? 32'd48 : 32'd60;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; fifo_full = 0; unused_slot = 0; slot_tick = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic reg_wr(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = v;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic cmd_wr(input logic [5:0] c, input logic [15:0] a);
    @(negedge clk); cmd_we = 1; cmd_code = c; cmd_addr = a;
    @(posedge clk); #1 cmd_we = 0;
  endtask

  task automatic data_wr(input logic [15:0] v);
    @(negedge clk); data_we = 1; data_wval = v; slot_tick = 0;
    #1 c_acc = data_accept; c_now = tnow;
    @(posedge clk); #1 data_we = 0;
  endtask

  task automatic do_slot(input int s, input bit u);
    @(negedge clk); slot_tick = 1; slot_num = s[7:0]; unused_slot = u;
    #1 c_ext = ext_rd; c_clr = unused_clr; c_eaddr = ext_addr; c_now = tnow;
    @(posedge clk); #1 slot_tick = 0; unused_slot = 0;
  endtask

  task automatic setup(input logic [7:0] hi, mid, lo, input logic [15:0] ln, input logic [7:0] inc);
    reg_wr(3'd2, hi); reg_wr(3'd1, mid); reg_wr(3'd0, lo);
    reg_wr(3'd3, ln[7:0]); reg_wr(3'd4, ln[15:8]); reg_wr(3'd5, inc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] src, dest;
    int n;
    do_reset();
    chk("R12 reset running", dma_running, 0);
    chk("R12 reset valid", fe_valid, 0);

    // R1 R2 R3 R7 R11: full slot sweep, external mode, both widths
    for (int w = 0; w < 2; w++) begin
      do_reset();
      wide_mode = w[0];
      setup(8'h41, 8'h12, 8'hF0, 16'h0000, 8'h02);
      cmd_wr(6'h21, 16'h0100);
      chk("R12 start", dma_running, 1);
      src = 16'h12F0; dest = 16'h0100;
      for (int s = 0; s < 256; s++) begin
        bit e;
        e = !bref(s, w[0]) && (s == 0 || !bref(s - 1, w[0]));
        do_slot(s, 0);
        chk("R2 R3 read slot", c_ext, e);
        chk("R2 entry", fe_valid, e);
        if (e) begin
          chk("R3 R7 ext addr", c_eaddr, {8'h41, src});
          chk("R1 R3 value", fe_value, src ^ 16'h5A3C);
          chk("R7 dest", fe_addr, dest);
          chk("R11 ready", fe_ready, c_now + lat(w[0]));
          chk("R3 partial", fe_partial, 0);
          src = src + 1; dest = dest + 2;
        end
      end
    end

    // R6 R10 R8: full FIFO, rejected writes, end of run
    do_reset();
    wide_mode = 1;
    setup(8'h00, 8'h00, 8'h10, 16'd4, 8'h01);
    cmd_wr(6'h25, 16'h0030);
    fifo_full = 1;
    for (int s = 1; s < 9; s++) begin
      do_slot(s, 0);
      chk("R6 no read", c_ext, 0);
      chk("R6 no entry", fe_valid, 0);
    end
    data_wr(16'h1111);
    chk("R6 write refused", c_acc, 0);
    fifo_full = 0;
    data_wr(16'h2222);
    chk("R10 write rejected", c_acc, 0);
    chk("R10 no entry", fe_valid, 0);
    for (int s = 1; s < 5; s++) begin
      do_slot(s, 0);
      chk("R3 entry", fe_valid, 1);
      chk("R7 dest", fe_addr, 16'h0030 + 16'(s - 1));
    end
    chk("R8 ended", dma_running, 0);
    data_wr(16'h7777);
    chk("R10 accepted", c_acc, 1);
    chk("R10 value", fe_value, 16'h7777);
    chk("R10 addr", fe_addr, 16'h0034);
    chk("R8 code low bits", fe_code, 6'h05);
    chk("R10 partial", fe_partial, 0);

    // R4: copy for each destination type
    for (int k = 0; k < 3; k++) begin
      logic [3:0] code;
      logic [7:0] lo;
      logic [15:0] ev;
      code = (k == 0) ? 4'h1 : (k == 1) ? 4'h3 : 4'h5;
      do_reset();
      wide_mode = 1;
      setup(8'hC0, 8'h20, 8'h26, 16'd4, 8'h01);
      cmd_wr({2'b10, code}, 16'h0040);
      lo = 8'h26; n = 0;
      for (int i = 0; i < 8; i++) begin
        do_slot(i + 1, i[0]);
        chk("R4 clear pulse", c_clr, i[0]);
        chk("R4 entry", fe_valid, i[0]);
        if (i[0]) begin
          if (code == 4'h1) ev = {8'h00, lo ^ 8'h20 ^ 8'h11};
          else if (code == 4'h3) ev = {4'hC, lo[5:0], lo[5:0]};
          else ev = (lo[5:0] < 6'd40) ? (16'hE000 | {10'h0, lo[5:0]}) : 16'h0000;
          chk("R4 copy value", fe_value, ev);
          chk("R4 partial", fe_partial, 0);
          chk("R7 dest", fe_addr, 16'h0040 + 16'(n));
          lo = lo + 1; n++;
        end
      end
      chk("R8 copy ended", dma_running, 0);
    end

    // R5 R9: fill armed by a data write
    for (int k = 0; k < 2; k++) begin
      logic [3:0] code;
      code = k == 0 ? 4'h1 : 4'h3;
      do_reset();
      wide_mode = 0;
      setup(8'h80, 8'h00, 8'h00, 16'd3, 8'h02);
      cmd_wr({2'b10, code}, 16'h0200);
      chk("R9 cmd no start", dma_running, 0);
      data_wr(16'hABCD);
      chk("R9 write entry", fe_value, 16'hABCD);
      chk("R9 write partial", fe_partial, 0);
      chk("R9 armed", dma_running, 1);
      do_slot(24, 0);
      chk("R2 fill refresh", fe_valid, 0);
      for (int s = 1; s < 4; s++) begin
        do_slot(s, 0);
        chk("R5 entry", fe_valid, 1);
        chk("R5 value", fe_value, code == 4'h1 ? 16'h00AB : 16'hABCD);
        chk("R5 partial", fe_partial, 1);
        chk("R11 ready", fe_ready, c_now + 60);
        chk("R7 dest", fe_addr, 16'h0200 + 16'(2 * s));
      end
      chk("R8 fill ended", dma_running, 0);
    end

    // R8: zero length means 65536 entries
    do_reset();
    setup(8'h80, 8'h00, 8'h00, 16'd0, 8'h01);
    cmd_wr(6'h23, 16'h0000);
    data_wr(16'h0F0F);
    n = 0;
    while (dma_running && n < 70000) begin
      do_slot(1, 0);
      if (fe_valid) n++;
    end
    chk("R8 zero length count", n, 65536);
    chk("R8 zero length ended", dma_running, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule